// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product. It uses one adder and a single add-or-shift step per clock, so it trades latency for area. A one-cycle pulse on `start` captures both operands. The block then runs N steps, and a one-cycle `done` flag marks the point where `prod` holds the result. The product stays on `prod` until the next accepted start.

Internally, the multiplicand register feeds an N-bit adder, and an accumulator holds the upper half of the running result. The multiplier register is consumed one bit per step and slowly fills with the lower product bits. A loadable down-counter with a zero flag ends the step loop. A four-state controller (idle, load, step, finish) drives the register loads and the operand select. `start`, `done` and the operands are plain control and data pins with no handshake. The caller waits for `done` before it reads `prod` or issues a new `start`.

Top module: `seqmul_top`

## Requirements
- R1: Asserting `clr` at any time, even between clock edges, immediately forces `done` to 0 and `prod` to 0 and returns the controller to idle.
- R2: For any unsigned operands sampled at start, `prod` equals `a_in * b_in` (2N bits) when `done` is high.
- R3: `done` rises after exactly N+2 rising edges, counted from the edge that sampled `start` high in idle, and it stays high for exactly one clock.
- R4: Each step adds the multiplicand to the accumulator when the multiplier's low bit is 1 and keeps the carry out of that sum, so the all-ones times all-ones case yields the full 2N-bit result.
- R5: The accumulator is cleared when operands load, so a product never carries over a partial sum from an earlier run.
- R6: `start` is ignored while a multiplication is in progress (load, step or finish state). Neither the result nor the timing of the current run changes.
- R7: While the block is idle with `start` low, `prod` holds its value, including when `a_in` or `b_in` change.
- R8: Operands are captured only on the load edge. Changes to `a_in`/`b_in` during a run do not alter its product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous active-high clear |
| start | input | 1 | Begin a multiplication; sampled only in idle |
| a_in | input | N | Multiplicand operand |
| b_in | input | N | Multiplier operand |
| done | output | 1 | One-cycle flag: product is valid |
| prod | output | 2N | Product, accumulator concatenated with multiplier register |

## Verification
Directed operands cover the cases the adder and counter can get wrong. 13×11 tests a mixed bit pattern. Zero in either operand tests the all-shift and all-add-zero paths. The all-ones square exposes a dropped carry, 1×max and 128×2 show the shift alignment, and max followed by ×0 shows a stale accumulator. Random operands from a seeded `$urandom` then cover the remaining bit mixes. During the same runs, the bench fires stray `start` pulses and changes the operands mid-run, to separate a correct controller from one that restarts or samples the operands late. A clear asserted between edges checks that the reset does not wait for the clock.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ITER = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seqmul_step.sv
// One add-or-shift step: (carry:sum) of acc (+ mcand if mplier[0]),
// upper W bits to the accumulator, bit 0 into the multiplier's top bit.
module seqmul_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mplier,
  output logic [W-1:0] acc_nxt,
  output logic [W-1:0] mplier_nxt
);
  logic [W:0] wide;

  always_comb begin
    if (mplier[0]) wide = {1'b0, acc} + {1'b0, mcand};
    else           wide = {1'b0, acc};
    acc_nxt    = wide[W:1];
    mplier_nxt = {wide[0], mplier[W-1:1]};
  end
endmodule

// File: rtl/seqmul_cnt.sv
// Loadable down-counter with a zero flag and asynchronous clear.
module seqmul_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] din,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)       cnt_q <= '0;
    else if (load) cnt_q <= din;
    else           cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3: a freshly loaded nonzero count must not report zero on the next cycle
  a_r3_load_nonzero : assert property (@(posedge clk) disable iff (clr)
    (load && din != '0) |=> !zero);
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       start,
  input  logic       zero,
  output seq_state_e state,
  output logic       done,
  output logic       sel_ext,
  output logic       ld_a,
  output logic       ld_bc,
  output logic       ld_cnt
);
  seq_state_e st_q, st_d;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d    = st_q;
    done    = 1'b0;
    sel_ext = 1'b0;
    ld_a    = 1'b0;
    ld_bc   = 1'b0;
    ld_cnt  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_LOAD;
      ST_LOAD: begin
        st_d    = ST_ITER;
        sel_ext = 1'b1;
        ld_a    = 1'b1;
        ld_bc   = 1'b1;
        ld_cnt  = 1'b1;
      end
      ST_ITER: begin
        if (zero) st_d  = ST_FIN;
        else      ld_bc = 1'b1;
      end
      ST_FIN: begin
        st_d = ST_IDLE;
        done = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign state = st_q;

  // R3: the finish flag lasts one clock
  a_r3_done_single : assert property (@(posedge clk) disable iff (clr)
    done |=> !done);
  // R6: a start seen outside idle never re-enters the load state
  a_r6_start_ignored : assert property (@(posedge clk) disable iff (clr)
    (st_q != ST_IDLE && start) |=> st_q != ST_LOAD);
endmodule

// File: rtl/seqmul_top.sv
module seqmul_top
  import seqmul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           start,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic           done,
  output logic [2*N-1:0] prod
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] STEPS = CW'(N);

  seq_state_e state;
  logic sel_ext, ld_a, ld_bc, ld_cnt, zero;
  logic [N-1:0] a_q, b_q, c_q;
  logic [N-1:0] c_step, b_step, b_d, c_d;

  seqmul_ctrl u_ctrl (
    .clk(clk), .clr(clr), .start(start), .zero(zero),
    .state(state), .done(done), .sel_ext(sel_ext),
    .ld_a(ld_a), .ld_bc(ld_bc), .ld_cnt(ld_cnt)
  );

  seqmul_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .clr(clr), .load(ld_cnt), .din(STEPS), .zero(zero)
  );

  seqmul_step #(.W(N)) u_step (
    .mcand(a_q), .acc(c_q), .mplier(b_q),
    .acc_nxt(c_step), .mplier_nxt(b_step)
  );

  // operand select: external operands on load, step results otherwise
  assign b_d = sel_ext ? b_in : b_step;
  assign c_d = sel_ext ? '0   : c_step;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)       a_q <= '0;
    else if (ld_a) a_q <= a_in;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      b_q <= '0;
      c_q <= '0;
    end else if (ld_bc) begin
      b_q <= b_d;
      c_q <= c_d;
    end
  end

  assign prod = {c_q, b_q};

  // R5: accumulator starts from zero after a load
  a_r5_acc_cleared : assert property (@(posedge clk) disable iff (clr)
    (state == ST_LOAD) |=> c_q == '0);
  // R8: operands captured on the load edge
  a_r8_operands_captured : assert property (@(posedge clk) disable iff (clr)
    (state == ST_LOAD) |=> (a_q == $past(a_in) && b_q == $past(b_in)));
  // R7: idle without start keeps the product
  a_r7_prod_hold : assert property (@(posedge clk) disable iff (clr)
    (state == ST_IDLE && !start) |=> $stable(prod));
  // R3: finish only follows an expired counter
  a_r3_done_after_zero : assert property (@(posedge clk) disable iff (clr)
    $rose(done) |-> $past(zero));
endmodule

// File: tb/sim_seqmul_top.sv
`timescale 1ns/1ps
module sim_seqmul_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic start = 1'b0;
  logic [N-1:0] a_in = '0, b_in = '0;
  logic done;
  logic [2*N-1:0] prod;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  seqmul_top #(.N(N)) u0 (
    .clk(clk), .clr(clr), .start(start),
    .a_in(a_in), .b_in(b_in), .done(done), .prod(prod)
  );

  function automatic logic [2*N-1:0] expect_prod(logic [N-1:0] a, logic [N-1:0] b);
    return (2*N)'(a) * (2*N)'(b);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one multiplication; optionally disturb it mid-run (R6/R8)
  task automatic run_op(logic [N-1:0] a, logic [N-1:0] b, bit disturb, string req);
    int lat;
    logic [2*N-1:0] exp_p;
    exp_p = expect_prod(a, b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (disturb && lat == 3) begin
        start = 1'b1; a_in = N'($urandom); b_in = N'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({"R3 latency ", req}, lat, N + 3);
    check({"R2 product ", req}, prod, exp_p);
    @(negedge clk);
    check("R3 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2*N-1:0] held;
    void'($urandom(32'd1234));
    #35;
    check("R1 reset done", done, 0);
    check("R1 reset prod", prod, 0);
    @(negedge clk);
    clr = 1'b0;

    run_op(8'd13, 8'd11, 1'b0, "13x11");
    run_op(8'd0, 8'd200, 1'b0, "0xb");
    run_op(8'd77, 8'd0, 1'b0, "ax0");
    run_op(8'd255, 8'd255, 1'b0, "R4 all-ones carry");
    run_op(8'd1, 8'd255, 1'b0, "1xmax");
    run_op(8'd128, 8'd2, 1'b0, "128x2");
    run_op(8'd255, 8'd0, 1'b0, "R5 stale acc after max");

    // R7: product held while idle, operands moving
    held = prod;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a_in = N'($urandom); b_in = N'($urandom);
    end
    check("R7 prod held idle", prod, held);

    // R6/R8: stray start and operand changes mid-run
    run_op(8'd201, 8'd57, 1'b1, "R6 R8 disturbed");
    run_op(8'd99, 8'd3, 1'b1, "R6 R8 disturbed 2");

    for (int i = 0; i < 30; i++)
      run_op(N'($urandom), N'($urandom), (i % 4) == 0, "random");

    // R1: clear between edges, mid-run
    @(negedge clk);
    a_in = 8'd200; b_in = 8'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    #3 clr = 1'b1;
    #1;
    check("R1 async clr prod", prod, 0);
    check("R1 async clr done", done, 0);
    @(negedge clk);
    clr = 1'b0;
    run_op(8'd13, 8'd11, 1'b0, "R1 after clr");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule